// File: doc/BRIEF.md
# Packed Saturating Shift and Precision Unit

This unit is the shift and precision-conversion stage of a packed DSP datapath. One operand word holds several equal lanes: bytes, halfwords or words. A single operation code selects what is done to every lane: a left shift that reports lost significance, a left shift that clamps to the signed limits, a plain right shift, a right shift that rounds to nearest, a conversion that rounds a 32-bit fraction to 16 bits, or a conversion that narrows a signed 16-bit value to an unsigned byte.

All lanes work in parallel. The per-lane overflow indications are merged into one strobe. Result and strobe are registered, so an operation presented with `in_valid` in one cycle appears on the outputs after the next rising clock edge. The upstream control logic collects the strobe into its own sticky status.

Top module: `psat_shift_unit`

## Requirements
- R1: The outputs are registered. `out_valid` equals `in_valid` delayed by one clock, and `result` and `ovf` are updated from the operation presented in the previous cycle. After a cycle with `in_valid` low, `out_valid` and `ovf` are 0 and `result` keeps its value.
- R2: The shift amount is `amt[2:0]` for byte lanes (`lane`=0), `amt[3:0]` for halfword lanes (`lane`=1) and `amt[4:0]` for word lanes (`lane`=2). A shift operation with an amount of zero returns each lane unchanged and never raises `ovf`.
- R3: A left shift (`op`=0) by s>0 returns the lane shifted left with zero fill. It overflows when the s+1 most significant bits of the input lane are not all equal.
- R4: A saturating left shift (`op`=1) returns the same value as R3 when there is no overflow. On overflow the lane becomes the largest positive value (0x7F, 0x7FFF, 0x7FFFFFFF) if the input is non-negative, and the most negative value (0x80, 0x8000, 0x80000000) if it is negative.
- R5: A right shift (`op`=2) fills with zeros in byte lanes and copies the sign bit in halfword and word lanes. It never overflows.
- R6: A rounding right shift (`op`=3) by s>0 on halfword and word lanes gives floor((x + 2^(s-1)) / 2^s) for the signed lane value x. Byte lanes behave as in R5. It never overflows.
- R7: Round-to-16 (`op`=4) works on each 32-bit word. It adds 0x8000 to the signed word. If this overflows, the word is taken as 0x7FFFFFFF and `ovf` is raised. The upper half of the sum goes to bits 15:0 of the word lane, and bits 31:16 are zero. `lane` and `amt` are ignored.
- R8: Narrow-to-byte (`op`=5) works on each 16-bit halfword. A negative input gives 0x00 with `ovf`. An input above 0x7F80 gives 0xFF with `ovf`. Otherwise the output is bits 14:7 of the input. The byte goes to bits 7:0 of the halfword lane, and bits 15:8 are zero. `lane` and `amt` are ignored.
- R9: `ovf` is the OR of the overflow conditions of all lanes of one operation.
- R10: The operation codes 6 and 7, and shift operations with `lane`=3, return a zero result with `ovf` low.
- R11: While `rst_n` is low, `result`, `ovf` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation code (0 shl, 1 shl-sat, 2 shr, 3 shr-round, 4 round-to-16, 5 narrow-to-byte) |
| lane | input | 2 | Lane width for shifts (0 byte, 1 halfword, 2 word) |
| amt | input | 5 | Shift amount; low bits used per lane width |
| operand | input | DATA_W | Packed input lanes |
| result | output | DATA_W | Packed registered result |
| ovf | output | 1 | Overflow strobe for the result on `result` |
| out_valid | output | 1 | `result` and `ovf` hold a new operation |

## Verification
Every result and overflow strobe is due exactly one rising edge after its operation is presented. No path through the unit has a different delay. The bench drives stimulus on the falling edge and queues the reference value at the same moment. On the next falling edge it takes the oldest queued entry and compares it with the outputs, so each comparison is made half a period after the register has loaded. In cycles with nothing presented, the bench checks that the strobes are low and that the held result is unchanged at the same sampling point.

// File: rtl/pshf_pkg.sv
package pshf_pkg;

  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SHL_SAT = 3'd1,
    OP_SHR     = 3'd2,
    OP_SHR_RND = 3'd3,
    OP_RND16   = 3'd4,
    OP_RED8    = 3'd5
  } shf_op_e;

  typedef enum logic [1:0] {
    LN_BYTE = 2'd0,
    LN_HALF = 2'd1,
    LN_WORD = 2'd2
  } lane_e;

  // Round a signed 32-bit value to its upper half; bit 16 of the return is overflow.
  function automatic logic [16:0] rnd_trunc32(input logic [31:0] a);
    logic [32:0] sum;
    sum = {a[31], a} + 33'h0_0000_8000;
    if (sum[32] != sum[31]) return {1'b1, 16'h7FFF};
    return {1'b0, sum[31:16]};
  endfunction

  // Narrow a signed 16-bit value to an unsigned byte; bit 8 of the return is overflow.
  function automatic logic [8:0] reduce16(input logic [15:0] a);
    if (a[15]) return {1'b1, 8'h00};
    if (a[14:0] > 15'h7F80) return {1'b1, 8'hFF};
    return {1'b0, a[14:7]};
  endfunction

endpackage

// File: rtl/pshf_lane.sv
module pshf_lane
  import pshf_pkg::*;
#(
  parameter int W     = 16,
  parameter int AW    = 4,
  parameter bit ARITH = 1'b1
) (
  input  logic [2:0]    op,
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  y,
  output logic          ovf
);

  localparam logic [AW-1:0] TOP  = AW'(W - 1);
  localparam logic [W-1:0]  MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  MINN = {1'b1, {(W-1){1'b0}}};

  logic          zero_amt;
  logic [W-1:0]  shl_v;
  logic [W-1:0]  discard;
  logic          shl_ovf;
  logic [W-1:0]  sat_v;
  logic [W-1:0]  shr_v;
  logic [W-1:0]  rnd_v;

  assign zero_amt = (amt == '0);
  assign shl_v    = a << amt;
  // The top amt+1 bits end up in the low bits, sign-extended above.
  assign discard  = unsigned'($signed(a) >>> (TOP - amt));
  assign shl_ovf  = !zero_amt && (discard != '0) && (discard != '1);
  assign sat_v    = shl_ovf ? (a[W-1] ? MINN : MAXP) : shl_v;

  generate
    if (ARITH) begin : g_arith
      localparam logic [W:0] ONE_X = (W+1)'(1);
      logic [AW-1:0] sh1;
      logic [W:0]    pre;
      logic [W:0]    rnd_ext;
      assign sh1     = amt - AW'(1);
      assign pre     = unsigned'($signed({a[W-1], a}) >>> sh1);
      assign rnd_ext = pre + ONE_X;
      assign shr_v   = unsigned'($signed(a) >>> amt);
      assign rnd_v   = zero_amt ? a : rnd_ext[W:1];
    end else begin : g_logic
      assign shr_v = a >> amt;
      assign rnd_v = shr_v;
    end
  endgenerate

  always_comb begin
    y   = '0;
    ovf = 1'b0;
    case (op)
      OP_SHL:     begin y = shl_v; ovf = shl_ovf; end
      OP_SHL_SAT: begin y = sat_v; ovf = shl_ovf; end
      OP_SHR:     y = shr_v;
      OP_SHR_RND: y = rnd_v;
      default:    y = '0;
    endcase
  end

endmodule

// File: rtl/pshf_lane_bank.sv
module pshf_lane_bank #(
  parameter int DATA_W = 32,
  parameter int W      = 16,
  parameter int AW     = 4,
  parameter bit ARITH  = 1'b1
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [AW-1:0]     amt,
  output logic [DATA_W-1:0] y,
  output logic              ovf
);

  localparam int N = DATA_W / W;

  logic [N-1:0] lane_ovf;

  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      pshf_lane #(.W(W), .AW(AW), .ARITH(ARITH)) u_lane (
        .op  (op),
        .a   (operand[i*W +: W]),
        .amt (amt),
        .y   (y[i*W +: W]),
        .ovf (lane_ovf[i])
      );
    end
  endgenerate

  assign ovf = |lane_ovf;

endmodule

// File: rtl/pshf_narrow.sv
module pshf_narrow
  import pshf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] rt_y,
  output logic              rt_ovf,
  output logic [DATA_W-1:0] rd_y,
  output logic              rd_ovf
);

  localparam int NW = DATA_W / 32;
  localparam int NH = DATA_W / 16;

  logic [NW-1:0] rt_lane_ovf;
  logic [NH-1:0] rd_lane_ovf;

  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      logic [16:0] r;
      assign r                 = rnd_trunc32(operand[i*32 +: 32]);
      assign rt_y[i*32 +: 32]  = {16'h0000, r[15:0]};
      assign rt_lane_ovf[i]    = r[16];
    end
    for (genvar j = 0; j < NH; j++) begin : g_half
      logic [8:0] r;
      assign r                 = reduce16(operand[j*16 +: 16]);
      assign rd_y[j*16 +: 16]  = {8'h00, r[7:0]};
      assign rd_lane_ovf[j]    = r[8];
    end
  endgenerate

  assign rt_ovf = |rt_lane_ovf;
  assign rd_ovf = |rd_lane_ovf;

endmodule

// File: rtl/psat_shift_unit.sv
module psat_shift_unit
  import pshf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        lane,
  input  logic [4:0]        amt,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              out_valid
);

  localparam int BYTE_AW = 3;
  localparam int HALF_AW = 4;
  localparam int WORD_AW = 5;

  logic [DATA_W-1:0] byte_y, half_y, word_y, rt_y, rd_y;
  logic              byte_ovf, half_ovf, word_ovf, rt_ovf, rd_ovf;
  logic [DATA_W-1:0] nxt_y;
  logic              nxt_ovf;

  pshf_lane_bank #(.DATA_W(DATA_W), .W(8), .AW(BYTE_AW), .ARITH(1'b0)) u_byte (
    .op(op), .operand(operand), .amt(amt[BYTE_AW-1:0]), .y(byte_y), .ovf(byte_ovf)
  );

  pshf_lane_bank #(.DATA_W(DATA_W), .W(16), .AW(HALF_AW), .ARITH(1'b1)) u_half (
    .op(op), .operand(operand), .amt(amt[HALF_AW-1:0]), .y(half_y), .ovf(half_ovf)
  );

  pshf_lane_bank #(.DATA_W(DATA_W), .W(32), .AW(WORD_AW), .ARITH(1'b1)) u_word (
    .op(op), .operand(operand), .amt(amt[WORD_AW-1:0]), .y(word_y), .ovf(word_ovf)
  );

  pshf_narrow #(.DATA_W(DATA_W)) u_narrow (
    .operand(operand), .rt_y(rt_y), .rt_ovf(rt_ovf), .rd_y(rd_y), .rd_ovf(rd_ovf)
  );

  always_comb begin
    nxt_y   = '0;
    nxt_ovf = 1'b0;
    case (op)
      OP_SHL, OP_SHL_SAT, OP_SHR, OP_SHR_RND: begin
        case (lane)
          LN_BYTE: begin nxt_y = byte_y; nxt_ovf = byte_ovf; end
          LN_HALF: begin nxt_y = half_y; nxt_ovf = half_ovf; end
          LN_WORD: begin nxt_y = word_y; nxt_ovf = word_ovf; end
          default: begin nxt_y = '0;     nxt_ovf = 1'b0;     end
        endcase
      end
      OP_RND16: begin nxt_y = rt_y; nxt_ovf = rt_ovf; end
      OP_RED8:  begin nxt_y = rd_y; nxt_ovf = rd_ovf; end
      default:  begin nxt_y = '0;   nxt_ovf = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      ovf       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_y;
        ovf    <= nxt_ovf;
      end else begin
        ovf    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/psat_shift_chk.sv
module psat_shift_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [1:0]        lane,
  input logic [4:0]        amt,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] result,
  input logic              ovf,
  input logic              out_valid
);

  logic       is_shift;
  logic [4:0] eff_amt;
  logic       zshift;
  logic       reserved;

  assign is_shift = (op <= 3'd3);
  assign eff_amt  = (lane == 2'd0) ? {2'b00, amt[2:0]} :
                    (lane == 2'd1) ? {1'b0, amt[3:0]}  : amt;
  assign zshift   = in_valid && is_shift && (lane != 2'd3) && (eff_amt == 5'd0);
  assign reserved = in_valid && ((op > 3'd5) || (is_shift && lane == 2'd3));

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !ovf && $stable(result)));

  assert_zero_amt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zshift |=> (!ovf && result == $past(operand)));

  assert_sat_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1 && lane == 2'd2 && !operand[31])
      |=> (!ovf || result[31:0] == 32'h7FFF_FFFF));

  assert_rnd16_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> (result[31:16] == 16'h0000));

  assert_red8_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5) |=> (result[15:8] == 8'h00));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> (result == '0 && !ovf));

endmodule

bind psat_shift_unit psat_shift_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane(lane),
  .amt(amt), .operand(operand), .result(result), .ovf(ovf), .out_valid(out_valid)
);

// File: tb/tb_psat_shift_unit.sv
module tb_psat_shift_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [2:0]        op;
  logic [1:0]        lane;
  logic [4:0]        amt;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic              ovf;
  logic              out_valid;

  psat_shift_unit #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane(lane),
    .amt(amt), .operand(operand), .result(result), .ovf(ovf), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  bit          finished = 0;
  bit [31:0]   exp_y_q[$];
  bit          exp_o_q[$];
  string       tag_q[$];
  bit          prev_valid = 0;
  bit [31:0]   held = 0;

  function automatic longint sext(longint a, int w);
    longint sb;
    sb = longint'(1) <<< (w - 1);
    return (a ^ sb) - sb;
  endfunction

  // Behavioural model of one lane of a shift operation.
  function automatic void ref_lane(int o, int w, longint a, int s,
                                   output longint y, output bit ov);
    longint mask, sa, top, allone;
    mask = (longint'(1) <<< w) - 1;
    sa   = sext(a, w);
    ov   = 0;
    y    = a;
    case (o)
      0, 1: begin
        if (s != 0) begin
          allone = (longint'(1) <<< (s + 1)) - 1;
          top    = (a >>> (w - 1 - s)) & allone;
          ov     = (top != 0) && (top != allone);
          y      = (a <<< s) & mask;
          if (o == 1 && ov)
            y = (sa < 0) ? (longint'(1) <<< (w - 1)) : ((longint'(1) <<< (w - 1)) - 1);
        end
      end
      2: y = (w == 8) ? (a >>> s) : ((sa >>> s) & mask);
      3: begin
        if (w == 8)      y = a >>> s;
        else if (s == 0) y = a;
        else             y = (((sa >>> (s - 1)) + 1) >>> 1) & mask;
      end
      default: y = 0;
    endcase
  endfunction

  function automatic void ref_word(int o, int ln, int am, bit [31:0] opd,
                                   output bit [31:0] y, output bit ov, output string tag);
    int     w, s;
    longint ly, sum;
    bit     lo;
    y = 0; ov = 0;
    if (o <= 3) begin
      if (ln == 3) begin tag = "R10"; return; end
      w = (ln == 0) ? 8 : (ln == 1) ? 16 : 32;
      s = am & (w - 1);
      case (o)
        0: tag = "R3";
        1: tag = "R4";
        2: tag = "R5";
        default: tag = "R6";
      endcase
      if (s == 0) tag = "R2";
      for (int k = 0; k < 32 / w; k++) begin
        ref_lane(o, w, longint'((opd >> (k * w)) & ((64'd1 << w) - 1)), s, ly, lo);
        y  = y | (32'(ly) << (k * w));
        ov = ov | lo;
      end
    end else if (o == 4) begin
      tag = "R7";
      sum = sext(longint'(opd), 32) + 32768;
      if (sum > 64'sd2147483647) begin y = 32'h0000_7FFF; ov = 1; end
      else y = 32'((sum >>> 16) & 16'hFFFF);
    end else if (o == 5) begin
      tag = "R8";
      for (int k = 0; k < 2; k++) begin
        longint h;
        h = longint'((opd >> (16 * k)) & 32'hFFFF);
        if (h >= 32768)      begin ov = 1; end
        else if (h > 32640) begin ov = 1; y = y | (32'hFF << (16 * k)); end
        else                 y = y | (32'(h / 128) << (16 * k));
      end
    end else begin
      tag = "R10";
    end
  endfunction

  task automatic check_outputs();
    bit [31:0] ey;
    bit        eo;
    string     t;
    checks++;
    if (out_valid !== prev_valid) begin
      fails++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, prev_valid);
    end
    if (prev_valid) begin
      ey = exp_y_q.pop_front();
      eo = exp_o_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (result !== ey) begin
        fails++;
        $display("FAIL %s result actual=%h expected=%h", t, result, ey);
      end
      checks++;
      if (ovf !== eo) begin
        fails++;
        $display("FAIL %s R9 ovf actual=%0b expected=%0b", t, ovf, eo);
      end
    end else begin
      checks++;
      if (ovf !== 1'b0 || result !== held) begin
        fails++;
        $display("FAIL R1 idle actual=%h/%0b expected=%h/0", result, ovf, held);
      end
    end
    held = result;
  endtask

  task automatic step(bit v, int o, int ln, int am, bit [31:0] opd);
    bit [31:0] ey;
    bit        eo;
    string     t;
    @(negedge clk);
    check_outputs();
    in_valid = v;
    op       = 3'(o);
    lane     = 2'(ln);
    amt      = 5'(am);
    operand  = opd;
    if (v) begin
      ref_word(o, ln, am, opd, ey, eo, t);
      exp_y_q.push_back(ey);
      exp_o_q.push_back(eo);
      tag_q.push_back(t);
    end
    prev_valid = v;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit [31:0] pats [8];
    pats = '{32'h7F3A_8001, 32'h80C5_FFFF, 32'h0000_0001, 32'h4040_4040,
             32'hFFFF_FFFF, 32'h0100_FE02, 32'hC000_3FFF, 32'h8000_0000};
    rst_n = 0; in_valid = 0; op = 0; lane = 0; amt = 0; operand = 0;
    repeat (3) @(negedge clk);
    checks++;  // R11: reset state
    if (result !== '0 || ovf !== 1'b0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset actual=%h/%0b/%0b expected=0/0/0", result, ovf, out_valid);
    end
    rst_n = 1;
    held = 0;
    // Every shift operation, every lane width and every shift amount.
    for (int o = 0; o < 4; o++)
      for (int ln = 0; ln < 3; ln++)
        for (int am = 0; am < 32; am++)
          for (int p = 0; p < 8; p++)
            step(1, o, ln, am, pats[p]);
    // Idle gaps between operations (R1).
    step(1, 0, 2, 5, 32'h1234_5678);
    step(0, 0, 0, 0, 32'hDEAD_BEEF);
    step(0, 1, 1, 3, 32'h0);
    // Round-to-16 corners (R7).
    step(1, 4, 0, 9, 32'h7FFF_8000);
    step(1, 4, 3, 0, 32'h7FFF_7FFF);
    step(1, 4, 1, 1, 32'h8000_0000);
    step(1, 4, 2, 2, 32'hFFFF_8000);
    step(1, 4, 0, 0, 32'h0001_7FFF);
    // Narrow-to-byte corners (R8).
    step(1, 5, 0, 0, 32'h7F80_7F81);
    step(1, 5, 2, 7, 32'h8000_0100);
    step(1, 5, 1, 3, 32'h007F_0080);
    step(1, 5, 3, 31, 32'h7FFF_0000);
    // Reserved codes (R10).
    step(1, 6, 2, 4, 32'hFFFF_FFFF);
    step(1, 7, 0, 1, 32'h8000_0001);
    step(1, 0, 3, 3, 32'hC000_0000);
    step(1, 3, 3, 2, 32'h1111_1111);
    // Random mix.
    for (int i = 0; i < 2000; i++)
      step(($urandom % 5) != 0, $urandom % 8, $urandom % 4, $urandom % 32, $urandom);
    step(0, 0, 0, 0, 32'h0);
    step(0, 0, 0, 0, 32'h0);
    finished = 1;
    summary();
    $finish;
  end

endmodule